// File: doc/BRIEF.md
# Auto-Reload Interval Timer

An up-counting timer meant to produce the periodic or single-shot tick of an operating system. A prescaler divides the input clock by its programmed value plus one. The divided ticks advance a counter from zero up to a reload limit. When the counter reaches that limit it raises an update event, clears itself and, in periodic operation, keeps counting. The update event sets a sticky flag. Software clears the flag, and the interrupt line carries the flag gated by an enable bit.

Software programs the timer through a word register port: a write strobe, a byte address and 32-bit write data, with combinational read data for the address presented. The reload limit can be double-buffered, so that a new value waits for the next update. A single-shot mode stops the counter after one update. A software-forced update restarts the count and loads the buffered prescaler and limit values. The width of the counter and reload register is a parameter (16 by default, or 32). Upper bits that are not implemented read as zero, which lets software discover the counter width.

The run control is a two-state machine. `TT_IDLE` is stopped and `TT_RUN` is counting. The START transition (IDLE to RUN) happens on a control write with bit 0 set. The STOP transition (RUN to IDLE) happens on a control write with bit 0 clear. The PULSE_END transition (RUN to IDLE) happens on an update event while single-shot mode is selected and no control write occurs in the same cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: With prescaler value P and reload value A, the first update occurs (A+1)(P+1) clocks after the control write that starts the timer, and further updates follow every (A+1)(P+1) clocks in periodic mode.
- R3: A prescaler write (address 0x28, bits 15:0) does not change the division in use until the next update event.
- R4: Writing 1 to bit 0 of address 0x14 forces an update. The update clears the counter and prescaler count, loads the prescaler and the reload value, and sets the flag. The next overflow follows a full (A+1)(P+1) clocks later. Address 0x14 reads zero.
- R5: With control bit 7 (preload) set, a write to the reload register (address 0x2C) takes effect only at the next update event.
- R6: With control bit 7 clear, a reload write takes effect at once, for the period that is already running.
- R7: With control bit 3 (single-shot) set, the first update returns the machine to `TT_IDLE`. Control bit 0 then reads 0, bit 3 stays set, and no further update occurs.
- R8: Status bit 0 (address 0x10) is set by every update event. Writing 0 to it clears it and writing 1 has no effect. An update in the same cycle as a clearing write leaves it set.
- R9: `irq` equals status bit 0 ANDed with bit 0 of address 0x0C.
- R10: Readback truncates to the implemented width. After a write of all ones, the reload register returns ones only in its CW low bits, the prescaler returns 0x0000FFFF, control returns only bits 7 and 3 (and 0 when running), and an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Update interrupt |

## Verification
The update event and a software write that clears the flag can fall in the same clock cycle. The bench measures the period of a running timer and then places a clearing write exactly on the edge of the next overflow. The flag must survive, so `irq` stays high. A control case lands the clearing write one cycle later and expects `irq` to drop. A forced update placed in the middle of a running period is likewise judged by the time of the next overflow, which must come a full period after the forced update.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_IEN  = 8'h0C;
    localparam logic [7:0] ADR_STAT = 8'h10;
    localparam logic [7:0] ADR_EVT  = 8'h14;
    localparam logic [7:0] ADR_DIV  = 8'h28;
    localparam logic [7:0] ADR_LIM  = 8'h2C;

    localparam int BIT_RUN   = 0;
    localparam int BIT_PULSE = 3;
    localparam int BIT_BUF   = 7;

    typedef enum logic [0:0] {
        TT_IDLE = 1'b0,
        TT_RUN  = 1'b1
    } tt_state_e;
endpackage

// File: rtl/tt_regfile.sv
`timescale 1ns/1ps
module tt_regfile
    import tick_timer_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [31:0]   wdata,
    input  logic          update_evt,
    input  logic          running,
    output logic [31:0]   rdata,
    output logic          opm_q,
    output logic          arpe_q,
    output logic          ier_q,
    output logic          sr_q,
    output logic [PW-1:0] psc_q,
    output logic [CW-1:0] arr_q,
    output logic          ug_pulse,
    output logic          ctrl_wr,
    output logic          cen_wr
);
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    logic sel_ien, sel_stat, sel_div, sel_lim;

    assign ctrl_wr  = wr_en && (addr == ADR_CTRL);
    assign sel_ien  = wr_en && (addr == ADR_IEN);
    assign sel_stat = wr_en && (addr == ADR_STAT);
    assign sel_div  = wr_en && (addr == ADR_DIV);
    assign sel_lim  = wr_en && (addr == ADR_LIM);
    assign ug_pulse = wr_en && (addr == ADR_EVT) && wdata[0];
    assign cen_wr   = wdata[BIT_RUN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opm_q  <= 1'b0;
            arpe_q <= 1'b0;
            ier_q  <= 1'b0;
            sr_q   <= 1'b0;
            psc_q  <= '0;
            arr_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                opm_q  <= wdata[BIT_PULSE];
                arpe_q <= wdata[BIT_BUF];
            end
            if (sel_ien) ier_q <= wdata[0];
            if (sel_div) psc_q <= wdata[PW-1:0];
            if (sel_lim) arr_q <= wdata[CW-1:0];
            // hardware set has priority over a software clear
            if (update_evt)
                sr_q <= 1'b1;
            else if (sel_stat && !wdata[0])
                sr_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata = 32'({arpe_q, 3'b000, opm_q, 2'b00, running});
            ADR_IEN:  rdata = 32'(ier_q);
            ADR_STAT: rdata = 32'(sr_q);
            ADR_DIV:  rdata = 32'(psc_q);
            ADR_LIM:  rdata = 32'(arr_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tt_prescaler.sv
`timescale 1ns/1ps
module tt_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ug_pulse,
    input  logic          update_evt,
    input  logic [PW-1:0] psc_q,
    output logic          tick,
    output logic [PW-1:0] psc_act
);
    logic [PW-1:0] div_cnt;

    assign tick = run && !ug_pulse && (div_cnt == psc_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            psc_act <= '0;
        end else begin
            if (ug_pulse)
                div_cnt <= '0;
            else if (run)
                div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (update_evt)
                psc_act <= psc_q;
        end
    end
endmodule

// File: rtl/tt_core.sv
`timescale 1ns/1ps
module tt_core
    import tick_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ug_pulse,
    input  logic          ctrl_wr,
    input  logic          cen_wr,
    input  logic          opm_q,
    input  logic          arpe_q,
    input  logic [CW-1:0] arr_q,
    output logic          running,
    output logic          update_evt,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] arr_act
);
    tt_state_e state, state_nxt;
    logic [CW-1:0] limit;
    logic          ovf;

    assign limit      = arpe_q ? arr_act : arr_q;
    assign ovf        = tick && (cnt_q == limit);
    assign update_evt = ovf || ug_pulse;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TT_IDLE;
        else        state <= state_nxt;
    end

    // transitions: START, STOP, PULSE_END
    always_comb begin
        state_nxt = state;
        unique case (state)
            TT_IDLE: if (ctrl_wr && cen_wr) state_nxt = TT_RUN;
            TT_RUN: begin
                if (ctrl_wr && !cen_wr)
                    state_nxt = TT_IDLE;
                else if (!ctrl_wr && opm_q && update_evt)
                    state_nxt = TT_IDLE;
            end
            default: state_nxt = TT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = (state == TT_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            arr_act <= '0;
        end else begin
            if (ug_pulse)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= ovf ? '0 : cnt_q + 1'b1;
            if (update_evt)
                arr_act <= arr_q;
        end
    end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    logic          opm_q, arpe_q, ier_q, sr_q;
    logic          ug_pulse, ctrl_wr, cen_wr;
    logic          running, update_evt, tick;
    logic [PW-1:0] psc_q, psc_act;
    logic [CW-1:0] arr_q, arr_act, cnt_q;

    tt_regfile #(.CW(CW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .update_evt(update_evt), .running(running), .rdata(rdata),
        .opm_q(opm_q), .arpe_q(arpe_q), .ier_q(ier_q), .sr_q(sr_q),
        .psc_q(psc_q), .arr_q(arr_q), .ug_pulse(ug_pulse),
        .ctrl_wr(ctrl_wr), .cen_wr(cen_wr)
    );

    tt_prescaler #(.PW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(running), .ug_pulse(ug_pulse),
        .update_evt(update_evt), .psc_q(psc_q), .tick(tick), .psc_act(psc_act)
    );

    tt_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ug_pulse(ug_pulse),
        .ctrl_wr(ctrl_wr), .cen_wr(cen_wr), .opm_q(opm_q), .arpe_q(arpe_q),
        .arr_q(arr_q), .running(running), .update_evt(update_evt),
        .cnt_q(cnt_q), .arr_act(arr_act)
    );

    assign irq = sr_q & ier_q;
endmodule

// File: rtl/tt_checker.sv
`timescale 1ns/1ps
module tt_checker
    import tick_timer_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    addr,
    input logic [31:0]   wdata,
    input logic          irq,
    input logic          update_evt,
    input logic          ug_pulse,
    input logic          sr_q,
    input logic          ier_q,
    input logic          running,
    input logic          opm_q,
    input logic          arpe_q,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] arr_act,
    input logic [PW-1:0] psc_act
);
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> sr_q);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q && !(wr_en && addr == ADR_STAT && !wdata[0]) |=> sr_q);

    p_pulse_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running && opm_q && update_evt && !(wr_en && addr == ADR_CTRL) |=> !running);

    p_forced_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ug_pulse |=> (cnt_q == '0));

    p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !update_evt |=> $stable(psc_act));

    p_limit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arpe_q && !update_evt |=> $stable(arr_act));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_q |-> !irq);
endmodule

bind tick_timer tt_checker #(.CW(CW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .update_evt(update_evt), .ug_pulse(ug_pulse), .sr_q(sr_q),
    .ier_q(ier_q), .running(running), .opm_q(opm_q), .arpe_q(arpe_q),
    .cnt_q(cnt_q), .arr_act(arr_act), .psc_act(psc_act)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    localparam int CW = 16;
    localparam int PW = 16;
    localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10;
    localparam logic [7:0] A_EVT = 8'h14, A_DIV = 8'h28, A_LIM = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int last = 0;

    tick_timer #(.CW(CW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(int a, int p);
        return (a + 1) * (p + 1);
    endfunction

    function automatic logic [31:0] width_mask(int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_at(int t, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        while (cyc < t - 1) @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        last = cyc;
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_at(0, a, d);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_irq(output int at);
        at = -1;
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk);
            #1;
            if (irq) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic setup(int p, int a, logic [31:0] ctrl_val);
        wr(A_CTRL, 0);
        wr(A_DIV, p);
        wr(A_LIM, a);
        wr(A_EVT, 1);
        wr(A_STAT, 0);
        wr(A_IEN, 1);
        wr(A_CTRL, ctrl_val);
    endtask

    initial begin
        #750000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int e0, c, c2, a, p;
        void'($urandom(32'd1234));

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 32'(irq), 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_IEN, v);  check("R1 ien", v, 0);
        rd(A_STAT, v); check("R1 stat", v, 0);
        rd(A_DIV, v);  check("R1 div", v, 0);
        rd(A_LIM, v);  check("R1 lim", v, 0);

        // R10: width-truncating readback
        wr(A_LIM, 32'hFFFF_FFFF); rd(A_LIM, v); check("R10 lim", v, width_mask(CW));
        wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, v); check("R10 div", v, width_mask(PW));
        wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); check("R10 ctrl", v, 32'h88);
        wr(A_CTRL, 0);
        wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, v); check("R10 ien", v, 1);
        wr(A_IEN, 0);
        rd(8'h04, v); check("R10 unmapped", v, 0);
        rd(A_EVT, v); check("R4 evt reads zero", v, 0);

        // R4/R9: forced update with interrupt disabled
        wr(A_DIV, 2); wr(A_LIM, 3);
        wr(A_EVT, 1);
        rd(A_STAT, v); check("R4 forced sets flag", v, 1);
        check("R9 irq masked", 32'(irq), 0);
        wr(A_STAT, 1); rd(A_STAT, v); check("R8 write one keeps set", v, 1);
        wr(A_STAT, 0); rd(A_STAT, v); check("R8 write zero clears", v, 0);
        wr(A_STAT, 1); rd(A_STAT, v); check("R8 write one no set", v, 0);
        wr(A_IEN, 1);
        wr(A_EVT, 1);
        check("R9 irq follows flag", 32'(irq), 1);
        wr(A_STAT, 0);
        check("R9 irq drops", 32'(irq), 0);
        wr(A_CTRL, 1); e0 = last;
        wait_irq(c);
        check("R4 loaded prescaler latency", c - e0, period(3, 2));

        // R2: periodic, random limits and prescalers
        for (int k = 0; k < 5; k++) begin
            a = 1 + int'($urandom_range(11));
            p = int'($urandom_range(3));
            setup(p, a, 32'h01); e0 = last;
            wait_irq(c);
            check("R2 first latency", c - e0, period(a, p));
            wr(A_STAT, 0);
            wait_irq(c2);
            check("R2 period", c2 - c, period(a, p));
        end

        // R7: single-shot, random
        for (int k = 0; k < 5; k++) begin
            a = 1 + int'($urandom_range(14));
            p = int'($urandom_range(4));
            setup(p, a, 32'h09); e0 = last;
            wait_irq(c);
            check("R7 latency", c - e0, period(a, p));
            rd(A_CTRL, v); check("R7 stopped ctrl", v, 32'h08);
            wr(A_STAT, 0);
            repeat (3 * period(a, p)) @(posedge clk);
            #1 check("R7 no second update", 32'(irq), 0);
        end

        // R5: preload on, new limit waits for next update
        setup(0, 4, 32'h81);
        wait_irq(c);
        wr(A_STAT, 0);
        wr(A_LIM, 8);
        wait_irq(c2);
        check("R5 old limit kept", c2 - c, period(4, 0));
        wr(A_STAT, 0);
        wait_irq(c);
        check("R5 new limit", c - c2, period(8, 0));

        // R6: preload off, new limit at once
        setup(0, 4, 32'h01);
        wait_irq(c);
        wr(A_STAT, 0);
        wr(A_LIM, 8);
        wait_irq(c2);
        check("R6 immediate limit", c2 - c, period(8, 0));

        // R3: prescaler write buffered until update
        setup(0, 4, 32'h01);
        wait_irq(c);
        wr(A_STAT, 0);
        wr(A_DIV, 1);
        wait_irq(c2);
        check("R3 old division kept", c2 - c, period(4, 0));
        wr(A_STAT, 0);
        wait_irq(c);
        check("R3 new division", c - c2, period(4, 1));

        // R4: forced update in mid period restarts count
        setup(1, 3, 32'h01);
        wait_irq(c);
        wr(A_STAT, 0);
        wr_at(c + 4, A_EVT, 1);
        check("R4 forced flag", 32'(irq), 1);
        e0 = last;
        wr(A_STAT, 0);
        wait_irq(c2);
        check("R4 full period after forced", c2 - e0, period(3, 1));

        // R8: clear write on the overflow edge loses to the set
        setup(0, 5, 32'h01);
        wait_irq(c);
        wr(A_STAT, 0);
        wr_at(c + period(5, 0), A_STAT, 0);
        check("R8 set wins collision", 32'(irq), 1);
        wr(A_STAT, 0);
        check("R8 later clear works", 32'(irq), 0);

        wr(A_CTRL, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule